// File: doc/BRIEF.md
# Indexed-Access Multi-CPU Interrupt Controller

This block collects a set of level-sensitive interrupt lines and presents them to up to four processors. Software never edits bit vectors in place. To turn a source on or off for the whole system it writes the source number into a global set register or a global clear register. To hide or reveal a source for a single processor, that processor writes the number into its own set-mask or clear-mask register. The per-CPU registers are banked by the requester's CPU number. Every source also owns a small routing word that selects which processors may see it.

Each processor reads an acknowledge register to learn which source to service. The read returns the lowest-numbered source that is asserted and eligible for that processor, or the code 1023 when nothing is pending. The read does not clear anything, because sources are level-sensitive. Source 0 is the aggregated inter-processor doorbell line, source 1 is the aggregated message-signalled doorbell line, and the higher numbers are peripheral lines. One source, the per-CPU timer, bypasses the global enable and the routing word and is gated only by each processor's mask.

The register port is a request channel with valid/ready and a read-response channel with valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Writes produce no response. An accepted read places its data on `rsp_rdata` with `rsp_valid` high on the next cycle. The response stays there unchanged until `rsp_ready` is high. While a response is waiting and `rsp_ready` is low, `req_ready` is held low.

Top module: `ipic_core`

## Requirements
- R1: After reset every source is globally disabled, masked for every CPU and routed to no CPU. With any inputs, `irq_out` is zero, every acknowledge read returns 1023 and every routing word reads 0.
- R2: A read of offset 0x000 returns the number of sources in bits [11:2], with all other bits zero (0x80 for 32 sources).
- R3: A write to 0x030 sets, and a write to 0x034 clears, the global enable of the source whose number is in wdata[9:0]; the upper wdata bits are ignored. No other source changes. A number not below the source count has no effect.
- R4: A write to 0x048 masks, and a write to 0x04C unmasks, the source numbered in wdata[9:0] for the CPU given on `req_cpu` only. The masks of other CPUs and sources are unchanged, and an out-of-range number has no effect.
- R5: The routing word of source s is at 0x100 + 4*s. Bit n of wdata[3:0] routes the source to CPU n. It reads back in bits [3:0], with all other bits zero. An address past the last source reads 0 and ignores writes.
- R6: An ordinary source is eligible for CPU n only when it is asserted, globally enabled, routed to n, and unmasked for n. `irq_out[n]` is high, in the same cycle as the state and inputs, exactly when some source is eligible for n.
- R7: A read of 0x044 by CPU n returns in bits [9:0] the lowest-numbered source eligible for n, or 1023 when none is eligible. The upper bits are zero. The read changes no state, so repeated reads return the same value while the inputs stay the same.
- R8: The timer source (number 5) is eligible for CPU n whenever it is asserted and unmasked for n. Its global enable and its routing word have no effect.
- R9: A request is accepted when `req_valid` and `req_ready` are high together. A read response appears one cycle later and holds its data stable until `rsp_ready` is high. `req_ready` is low whenever a response is waiting and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 32 | Level of each interrupt source, active high |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Requesting CPU; selects the banked per-CPU registers |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 4 | Interrupt request to each CPU |

## Verification
The assertions assume that reset is applied before the first clock that matters. They also assume that software changes the enable, mask and routing state only through the register port, so each accepted write can change at most one enable bit or one mask bit. The response-hold check assumes the consumer may leave `rsp_ready` low for any number of cycles. The stimulus exercises this with a deliberate stall, during which the source levels change under a pending acknowledge response. The random phase sends out-of-range numbers and addresses on purpose; these are legal inputs that must leave the state untouched.

// File: rtl/ipic_pkg.sv
`timescale 1ns/1ps
package ipic_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 10;
  localparam logic [IDX_W-1:0] SPURIOUS = 10'h3FF;

  localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SET_EN     = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_CLR_EN     = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ACK        = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_SET_MSK    = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_CLR_MSK    = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;
endpackage

// File: rtl/ipic_bus.sv
`timescale 1ns/1ps
module ipic_bus
  import ipic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CPU  = 4,
  parameter int DATA_W = 32,
  parameter int CPU_W  = 2,
  parameter int SW     = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [CPU_W-1:0]                  req_cpu,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [DATA_W-1:0]                 rsp_rdata,
  output logic                              set_en_we,
  output logic                              clr_en_we,
  output logic                              set_msk_we,
  output logic                              clr_msk_we,
  output logic                              route_we,
  output logic [SW-1:0]                     wr_sel,
  output logic [CPU_W-1:0]                  wr_cpu,
  output logic [N_CPU-1:0]                  wr_route,
  input  logic [N_SRC-1:0][N_CPU-1:0]       route_q,
  input  logic [N_CPU-1:0][IDX_W-1:0]       ack_idx
);
  logic              accept;
  logic              wr_acc;
  logic              rd_acc;
  logic [ADDR_W-1:0] roff;
  logic              route_hit;
  logic              idx_ok;
  logic              cpu_ok;
  logic [SW-1:0]     ridx;
  logic [DATA_W-1:0] rd_next;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_acc    = accept && !req_write;

  // routing window decode
  assign roff      = req_addr - OFS_ROUTE_BASE;
  assign route_hit = (req_addr >= OFS_ROUTE_BASE) && (roff[1:0] == 2'b00)
                     && (int'(roff[ADDR_W-1:2]) < N_SRC);
  assign ridx      = roff[SW+1:2];

  // index carried in write data for the set/clear registers
  assign idx_ok    = int'(req_wdata[IDX_W-1:0]) < N_SRC;
  assign cpu_ok    = int'(req_cpu) < N_CPU;

  assign set_en_we  = wr_acc && (req_addr == OFS_SET_EN)  && idx_ok;
  assign clr_en_we  = wr_acc && (req_addr == OFS_CLR_EN)  && idx_ok;
  assign set_msk_we = wr_acc && (req_addr == OFS_SET_MSK) && idx_ok && cpu_ok;
  assign clr_msk_we = wr_acc && (req_addr == OFS_CLR_MSK) && idx_ok && cpu_ok;
  assign route_we   = wr_acc && route_hit;
  assign wr_sel     = route_hit ? ridx : req_wdata[SW-1:0];
  assign wr_cpu     = req_cpu;
  assign wr_route   = req_wdata[N_CPU-1:0];

  always_comb begin
    rd_next = '0;
    if (req_addr == OFS_CTRL) begin
      rd_next[IDX_W+1:2] = IDX_W'(N_SRC);
    end else if (req_addr == OFS_ACK) begin
      rd_next[IDX_W-1:0] = cpu_ok ? ack_idx[req_cpu] : SPURIOUS;
    end else if (route_hit) begin
      rd_next[N_CPU-1:0] = route_q[ridx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response keeps its data
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/ipic_state.sv
`timescale 1ns/1ps
module ipic_state #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int CPU_W = 2,
  parameter int SW    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en_we,
  input  logic                        clr_en_we,
  input  logic                        set_msk_we,
  input  logic                        clr_msk_we,
  input  logic                        route_we,
  input  logic [SW-1:0]               wr_sel,
  input  logic [CPU_W-1:0]            wr_cpu,
  input  logic [N_CPU-1:0]            wr_route,
  output logic [N_SRC-1:0]            en_q,
  output logic [N_CPU-1:0][N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0][N_CPU-1:0] route_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (set_en_we) begin
      en_q[wr_sel] <= 1'b1;
    end else if (clr_en_we) begin
      en_q[wr_sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int c = 0; c < N_CPU; c++) begin
        if (wr_cpu == CPU_W'(c)) begin
          if (set_msk_we)      mask_q[c][wr_sel] <= 1'b1;
          else if (clr_msk_we) mask_q[c][wr_sel] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else begin
      for (int s = 0; s < N_SRC; s++) begin
        if (route_we && (wr_sel == SW'(s))) route_q[s] <= wr_route;
      end
    end
  end

  // R3: one register write touches at most one enable bit
  assert_single_enable_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q ^ $past(en_q)) <= 1);
  // R4: one register write touches at most one mask bit across all CPUs
  assert_single_mask_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_q ^ $past(mask_q)) <= 1);
endmodule

// File: rtl/ipic_select.sv
`timescale 1ns/1ps
module ipic_select
  import ipic_pkg::*;
#(
  parameter int N_SRC     = 32,
  parameter int N_CPU     = 4,
  parameter int SW        = 5,
  parameter int TIMER_SRC = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            src_lvl,
  input  logic [N_SRC-1:0]            en_q,
  input  logic [N_CPU-1:0][N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0][N_CPU-1:0] route_q,
  output logic [N_CPU-1:0]            irq_out,
  output logic [N_CPU-1:0][IDX_W-1:0] ack_idx
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_SRC-1:0] elig;
    logic [IDX_W-1:0] pick;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      if (s == TIMER_SRC) begin : g_timer
        assign elig[s] = src_lvl[s] & ~mask_q[c][s];
      end else begin : g_plain
        assign elig[s] = src_lvl[s] & ~mask_q[c][s] & en_q[s] & route_q[s][c];
      end
    end

    // lowest number wins
    always_comb begin
      pick = SPURIOUS;
      for (int s = N_SRC - 1; s >= 0; s--) begin
        if (elig[s]) pick = IDX_W'(s);
      end
    end

    assign irq_out[c] = |elig;
    assign ack_idx[c] = pick;

    // R6: request line and acknowledge code agree
    assert_irq_matches_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] == (pick != SPURIOUS));
    // R7: an acknowledged source is asserted and unmasked for this CPU
    assert_ack_source_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pick != SPURIOUS) |-> (src_lvl[pick[SW-1:0]] && !mask_q[c][pick[SW-1:0]]));
    // R8: an unmasked, asserted timer line always raises the request
    assert_timer_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_lvl[TIMER_SRC] && !mask_q[c][TIMER_SRC]) |-> irq_out[c]);
  end
endmodule

// File: rtl/ipic_core.sv
`timescale 1ns/1ps
module ipic_core
  import ipic_pkg::*;
#(
  parameter int N_SRC     = 32,
  parameter int N_CPU     = 4,
  parameter int TIMER_SRC = 5,
  parameter int DATA_W    = 32,
  localparam int CPU_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int SW       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [N_CPU-1:0]  irq_out
);
  logic                        set_en_we;
  logic                        clr_en_we;
  logic                        set_msk_we;
  logic                        clr_msk_we;
  logic                        route_we;
  logic [SW-1:0]               wr_sel;
  logic [CPU_W-1:0]            wr_cpu;
  logic [N_CPU-1:0]            wr_route;
  logic [N_SRC-1:0]            en_q;
  logic [N_CPU-1:0][N_SRC-1:0] mask_q;
  logic [N_SRC-1:0][N_CPU-1:0] route_q;
  logic [N_CPU-1:0][IDX_W-1:0] ack_idx;

  ipic_bus #(.N_SRC(N_SRC), .N_CPU(N_CPU), .DATA_W(DATA_W), .CPU_W(CPU_W), .SW(SW)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .set_en_we(set_en_we), .clr_en_we(clr_en_we),
    .set_msk_we(set_msk_we), .clr_msk_we(clr_msk_we), .route_we(route_we),
    .wr_sel(wr_sel), .wr_cpu(wr_cpu), .wr_route(wr_route),
    .route_q(route_q), .ack_idx(ack_idx)
  );

  ipic_state #(.N_SRC(N_SRC), .N_CPU(N_CPU), .CPU_W(CPU_W), .SW(SW)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_en_we(set_en_we), .clr_en_we(clr_en_we),
    .set_msk_we(set_msk_we), .clr_msk_we(clr_msk_we), .route_we(route_we),
    .wr_sel(wr_sel), .wr_cpu(wr_cpu), .wr_route(wr_route),
    .en_q(en_q), .mask_q(mask_q), .route_q(route_q)
  );

  ipic_select #(.N_SRC(N_SRC), .N_CPU(N_CPU), .SW(SW), .TIMER_SRC(TIMER_SRC)) u_sel (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .en_q(en_q), .mask_q(mask_q), .route_q(route_q),
    .irq_out(irq_out), .ack_idx(ack_idx)
  );
endmodule

// File: tb/sim_ipic_core.sv
`timescale 1ns/1ps
module sim_ipic_core;
  localparam int NS    = 32;
  localparam int NC    = 4;
  localparam int TIMER = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_lvl = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_cpu = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] irq_out;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  bit          men[NS];
  bit          mmask[NC][NS];
  bit [NC-1:0] mroute[NS];

  ipic_core u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // ---------------- reference model ----------------
  function automatic bit m_elig(int c, int s);
    if (!src_lvl[s] || mmask[c][s]) return 1'b0;
    if (s == TIMER) return 1'b1;
    return men[s] && mroute[s][c];
  endfunction

  function automatic logic [31:0] m_ack(int c);
    for (int s = 0; s < NS; s++) if (m_elig(c, s)) return 32'(s);
    return 32'h3FF;
  endfunction

  function automatic logic m_irq(int c);
    for (int s = 0; s < NS; s++) if (m_elig(c, s)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a, int cpu);
    int r;
    if (a == 12'h000) return 32'(NS) << 2;
    if (a == 12'h044) return m_ack(cpu);
    r = (int'(a) - 256) / 4;
    if (a >= 12'h100 && a[1:0] == 2'b00 && r < NS) return 32'(mroute[r]);
    return 32'h0;
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d, int cpu);
    int idx;
    int r;
    idx = int'(d[9:0]);
    r = (int'(a) - 256) / 4;
    if (a == 12'h030) begin
      if (idx < NS) men[idx] = 1'b1;
    end else if (a == 12'h034) begin
      if (idx < NS) men[idx] = 1'b0;
    end else if (a == 12'h048) begin
      if (idx < NS) mmask[cpu][idx] = 1'b1;
    end else if (a == 12'h04C) begin
      if (idx < NS) mmask[cpu][idx] = 1'b0;
    end else if (a >= 12'h100 && a[1:0] == 2'b00 && r < NS) begin
      mroute[r] = d[NC-1:0];
    end
  endtask

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input int cpu);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_cpu = 2'(cpu);
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    m_write(a, d, cpu);
    @(negedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input int cpu, output logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = 2'(cpu);
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R9 response valid one cycle after read", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input int cpu);
    logic [31:0] exp;
    logic [31:0] got;
    exp = m_read(a, cpu);
    bus_rd(a, cpu, got);
    chk(req, got, exp);
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk); #1;
    src_lvl = v;
  endtask

  // R6: request lines compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int c = 0; c < NC; c++)
        chk($sformatf("R6 irq_out[%0d]", c), 32'(irq_out[c]), 32'(m_irq(c)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=60000 cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    for (int s = 0; s < NS; s++) begin
      men[s] = 1'b0; mroute[s] = '0;
      for (int c = 0; c < NC; c++) mmask[c][s] = 1'b1;
    end
    src_lvl = '1;
    repeat (3) @(negedge clk);
    chk("R1 irq_out in reset", 32'(irq_out), 32'd0);
    chk("R9 no response in reset", 32'(rsp_valid), 32'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: nothing presented with every line asserted
    for (int c = 0; c < NC; c++) begin
      bus_rd(12'h044, c, d);
      chk("R1 ack after reset", d, 32'h3FF);
    end
    bus_rd(12'h10C, 0, d);
    chk("R1 routing word after reset", d, 32'h0);

    // R2
    bus_rd(12'h000, 1, d);
    chk("R2 source count field", d, 32'h80);

    // R3/R6: build up eligibility for source 7 on CPU0
    set_src(32'h0000_0280);
    bus_wr(12'h11C, 32'h1, 0);
    bus_wr(12'h04C, 32'd7, 0);
    bus_rd(12'h044, 0, d);
    chk("R6 routed+unmasked but disabled", d, 32'h3FF);
    bus_wr(12'h030, 32'd7, 2);
    bus_rd(12'h044, 0, d);
    chk("R3 set-enable makes source 7 visible", d, 32'd7);
    bus_wr(12'h04C, 32'd7, 1);
    bus_rd(12'h044, 1, d);
    chk("R6 not routed to CPU1", d, 32'h3FF);

    // R7: lowest number wins, reads are not destructive
    bus_wr(12'h030, 32'd9, 0);
    bus_wr(12'h124, 32'h3, 0);
    bus_wr(12'h04C, 32'd9, 0);
    bus_wr(12'h04C, 32'd9, 1);
    bus_rd(12'h044, 0, d);
    chk("R7 lowest of 7 and 9", d, 32'd7);
    bus_rd(12'h044, 0, d);
    chk("R7 repeated read unchanged", d, 32'd7);
    bus_rd(12'h044, 1, d);
    chk("R7 CPU1 sees 9", d, 32'd9);
    set_src(32'h0000_0200);
    bus_rd(12'h044, 0, d);
    chk("R7 level drop moves to 9", d, 32'd9);

    // R3: out-of-range and upper-bit handling
    bus_wr(12'h034, 32'd40, 0);
    bus_rd(12'h044, 0, d);
    chk("R3 out-of-range clear ignored", d, 32'd9);
    bus_wr(12'h034, 32'h0001_0009, 3);
    bus_rd(12'h044, 0, d);
    chk("R3 clear with upper bits set", d, 32'h3FF);
    bus_wr(12'h030, 32'd9, 0);

    // R4: masks are per CPU
    bus_wr(12'h048, 32'd9, 1);
    bus_rd(12'h044, 1, d);
    chk("R4 CPU1 masked source 9", d, 32'h3FF);
    bus_rd(12'h044, 0, d);
    chk("R4 CPU0 unaffected", d, 32'd9);
    bus_wr(12'h048, 32'd33, 0);
    bus_rd(12'h044, 0, d);
    chk("R4 out-of-range mask ignored", d, 32'd9);

    // R8: timer bypasses enable and routing
    set_src(32'h0000_0220);
    bus_wr(12'h04C, 32'd5, 2);
    bus_rd(12'h044, 2, d);
    chk("R8 timer seen by CPU2", d, 32'd5);
    bus_rd(12'h044, 3, d);
    chk("R8 timer masked on CPU3", d, 32'h3FF);
    bus_wr(12'h034, 32'd5, 0);
    bus_wr(12'h114, 32'h0, 0);
    bus_rd(12'h044, 2, d);
    chk("R8 enable and routing have no effect", d, 32'd5);
    bus_rd(12'h044, 0, d);
    chk("R8 timer masked on CPU0, 9 wins", d, 32'd9);

    // R5: routing word layout and window end
    bus_wr(12'h130, 32'hFFFF_FFF5, 0);
    bus_rd(12'h130, 0, d);
    chk("R5 routing readback keeps 4 bits", d, 32'h5);
    bus_wr(12'h180, 32'hF, 0);
    bus_rd(12'h180, 0, d);
    chk("R5 past last source reads zero", d, 32'h0);

    // R9: stalled response
    @(negedge clk); #1;
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h044; req_cpu = 2'd2;
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 1'b0;
    held = rsp_rdata;
    chk("R9 stalled data is ack", held, 32'd5);
    src_lvl = 32'h0000_0200;
    repeat (3) begin
      @(negedge clk);
      chk("R9 valid held", 32'(rsp_valid), 32'd1);
      chk("R9 data stable", rsp_rdata, held);
      chk("R9 ready low while stalled", 32'(req_ready), 32'd0);
    end
    #1 rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 response drained", 32'(rsp_valid), 32'd0);
    chk("R9 ready back", 32'(req_ready), 32'd1);

    // random mix against the model
    for (int i = 0; i < 500; i++) begin
      int op;
      int cpu;
      int idx;
      op  = int'($urandom_range(0, 6));
      cpu = int'($urandom_range(0, NC - 1));
      idx = int'($urandom_range(0, NS + 3));
      case (op)
        0: bus_wr(12'h030, 32'(idx), cpu);
        1: bus_wr(12'h034, 32'(idx), cpu);
        2: bus_wr(12'h048, 32'(idx), cpu);
        3: bus_wr(12'h04C, 32'(idx), cpu);
        4: bus_wr(12'(256 + 4 * idx), $urandom, cpu);
        5: rd_chk("R7 random ack", 12'h044, cpu);
        default: set_src($urandom);
      endcase
      if (i % 25 == 0) rd_chk("R5 random routing read", 12'(256 + 4 * idx), cpu);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule